// File: doc/BRIEF.md
# Serial EEPROM Target with One-Time Write Lock

This block is a two-wire bus target that behaves like a 256-byte serial EEPROM with a separate write-lock control. A system clock oversamples the bus clock (SCL) and bus data (SDA) lines, so the bus must run well below the system clock. The block pulls SDA low through an open-drain enable and never stretches the clock. Three strap pins choose where the array answers inside the 7-bit range 0x50–0x57. The same strap bits place a lock-control address 0x20 lower, in the range 0x30–0x37.

To write, a controller sends a write control byte, one word-address byte and then data bytes. To read, it sets the word address the same way, issues a repeated START and sends a read control byte. The block then returns bytes one after another until the controller answers with NACK. The internal pointer wraps from 0xFF to 0x00. Sending one data byte to the lock-control address sets a permanent lock on bytes 0x00–0x7F. From then on the lock-control address stops answering. Only the power-on reset clears the lock.

Top module: `eeprom_wp_target`

## Requirements
- R1: The block acknowledges a control byte whose 7-bit address equals {4'b1010, strap_i} in either direction. A control byte to any other address that is not the active lock address gets no acknowledge, and sda_oe_o stays low for that whole transaction.
- R2: A write sends the control byte (bit 0 = 0), then a word-address byte, then data bytes. Each byte is acknowledged. The data bytes are stored at the word address and at the addresses after it, and the address wraps from 0xFF to 0x00.
- R3: After a word-address write, a repeated START and a read control byte (bit 0 = 1), the block returns bytes starting at that word address, MSB first, one per byte slot. It keeps incrementing, with wrap, while the controller acknowledges. After the controller sends NACK it releases SDA.
- R4: An address-only write (a quick write) to {4'b0110, strap_i} is acknowledged while the lock is clear, and it does not set the lock.
- R5: A read control byte to the lock address is never acknowledged.
- R6: A data byte written to the lock address is acknowledged and sets the lock. After that, writes to bytes 0x00–0x7F are still acknowledged but leave the stored data unchanged. Bytes 0x80–0xFF stay writable.
- R7: Once the lock is set, the block acknowledges nothing at the lock address, quick writes included. Bus traffic never clears the lock.
- R8: With rst_n low at a clock edge, the block clears the lock, sets every array byte to 0x00 and releases SDA.
- R9: A START at any point abandons the current transaction and begins a new one. A STOP releases SDA. sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Low three address bits of both target addresses |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The bench uses a write across the 0xFF/0x00 boundary and reads it back, to catch a pointer that saturates or skips the wrap. It drives the lock address with a quick write, a read, a data write and then a second quick write. A design that sets the lock on a quick write, acknowledges the read, or keeps answering after locking shows up as a wrong acknowledge bit or wrong data read back. Writes to one byte on each side of the 0x80 boundary after locking catch a protect window of the wrong size. A START injected in the middle of a byte, a change of strap value and a mid-run reset check that the block restarts cleanly and that only reset clears the lock.

// File: rtl/eeprom_wp_pkg.sv
// Shared constants and types for the serial EEPROM target.
// Assumes a 7-bit bus address made of a fixed high nibble and three strap bits.
package eeprom_wp_pkg;
    localparam int WORD_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int STRAP_W  = 3;
    localparam int DEV_W    = 7;
    localparam logic [DEV_W-STRAP_W-1:0] MEM_HI  = 4'b1010;
    localparam logic [DEV_W-STRAP_W-1:0] LOCK_HI = 4'b0110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WORD,
        ST_DATA,
        ST_LOCKD,
        ST_READ,
        ST_SKIP
    } bus_state_t;
endpackage

// File: rtl/eeprom_line_sync.sv
// Brings SCL and SDA into the clk domain and flags SCL edges, START and STOP.
// Assumes the bus is at least several times slower than clk; idle lines are high.
module eeprom_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Edge and bus-condition flags, each one clk wide.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/eeprom_array.sv
// Byte array with a sticky lock that blocks writes to the lower half.
// Assumes one write per clk at most; read is combinational from rd_addr.
module eeprom_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          lock_set,
    output logic          locked
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic lock_q;
    logic low_half;

    assign low_half = ~wr_addr[AW-1];

    // Storage update and lock capture; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            lock_q <= 1'b0;
        end else begin
            if (lock_set) lock_q <= 1'b1;
            if (wr_en && !(lock_q && low_half)) mem[wr_addr] <= wr_data;
        end
    end

    // Read port and lock status out.
    always_comb begin
        rd_data = mem[rd_addr];
        locked  = lock_q;
    end

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    assert_low_half_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock_q && !wr_addr[AW-1]) |=> (mem[$past(wr_addr)] == $past(mem[wr_addr])));
endmodule

// File: rtl/eeprom_bus_fsm.sv
// Bus protocol engine: decodes control bytes, acknowledges, moves the pointer,
// issues array writes and the lock request, and shifts read data out.
// Assumes synchronized lines and single-clk edge flags from eeprom_line_sync.
module eeprom_bus_fsm
    import eeprom_wp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_s,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] strap,
    input  logic               locked,
    input  logic [DW-1:0]      rd_data,
    output logic [AW-1:0]      ptr_o,
    output logic               wr_en,
    output logic [DW-1:0]      wr_data,
    output logic               lock_set,
    output logic               sda_oe
);
    localparam int BCW = $clog2(DW + 1);
    localparam logic [BCW-1:0] BYTE_END = BCW'(DW);

    bus_state_t      state;
    logic [BCW-1:0]  bcnt;
    logic [DW-1:0]   shreg, txb;
    logic [AW-1:0]   ptr;
    logic            ack_slot, mslot;
    logic [DEV_W-1:0] mem_id, lock_id;
    logic            rx_state, byte_done;

    // Address decode and byte-complete strobe.
    always_comb begin
        mem_id    = {MEM_HI, strap};
        lock_id   = {LOCK_HI, strap};
        rx_state  = (state == ST_CTRL) || (state == ST_WORD) ||
                    (state == ST_DATA) || (state == ST_LOCKD);
        byte_done = scl_fall && rx_state && (bcnt == BYTE_END) && !ack_slot;
        wr_en     = byte_done && (state == ST_DATA);
        lock_set  = byte_done && (state == ST_LOCKD);
        wr_data   = shreg;
        ptr_o     = ptr;
    end

    // Bus state machine, bit counter, shifters and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bcnt     <= '0;
            shreg    <= '0;
            txb      <= '0;
            ptr      <= '0;
            ack_slot <= 1'b0;
            mslot    <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (start_det) begin
            state    <= ST_CTRL;
            bcnt     <= '0;
            ack_slot <= 1'b0;
            mslot    <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            bcnt     <= '0;
            ack_slot <= 1'b0;
            mslot    <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (scl_rise) begin
            if (rx_state && bcnt < BYTE_END) begin
                shreg <= {shreg[DW-2:0], sda_s};
                bcnt  <= bcnt + 1'b1;
            end else if (state == ST_READ) begin
                if (mslot) begin
                    if (sda_s) begin
                        state <= ST_SKIP;
                        mslot <= 1'b0;
                    end
                end else if (bcnt < BYTE_END) begin
                    bcnt <= bcnt + 1'b1;
                end
            end
        end else if (scl_fall) begin
            if (ack_slot) begin
                ack_slot <= 1'b0;
                bcnt     <= '0;
                if (state == ST_READ) begin
                    txb    <= rd_data;
                    ptr    <= ptr + 1'b1;
                    sda_oe <= ~rd_data[DW-1];
                end else begin
                    sda_oe <= 1'b0;
                end
            end else if (byte_done) begin
                ack_slot <= 1'b1;
                sda_oe   <= 1'b1;
                case (state)
                    ST_CTRL: begin
                        if (shreg[DW-1:1] == mem_id) begin
                            state <= shreg[0] ? ST_READ : ST_WORD;
                        end else if (shreg[DW-1:1] == lock_id && !shreg[0] && !locked) begin
                            state <= ST_LOCKD;
                        end else begin
                            state    <= ST_SKIP;
                            ack_slot <= 1'b0;
                            sda_oe   <= 1'b0;
                        end
                    end
                    ST_WORD: begin
                        ptr   <= shreg;
                        state <= ST_DATA;
                    end
                    ST_DATA:  ptr   <= ptr + 1'b1;
                    default:  state <= ST_SKIP;
                endcase
            end else if (state == ST_READ) begin
                if (mslot) begin
                    mslot  <= 1'b0;
                    bcnt   <= '0;
                    txb    <= rd_data;
                    ptr    <= ptr + 1'b1;
                    sda_oe <= ~rd_data[DW-1];
                end else if (bcnt == BYTE_END) begin
                    sda_oe <= 1'b0;
                    mslot  <= 1'b1;
                end else begin
                    sda_oe <= ~txb[3'(DW - 1 - int'(bcnt))];
                end
            end
        end
    end

    assert_drive_in_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    assert_start_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_CTRL && !sda_oe));

    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    assert_lock_from_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(state == ST_LOCKD));

    assert_no_lock_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && state == ST_CTRL && locked && shreg[DW-1:1] == lock_id) |=> !sda_oe);
endmodule

// File: rtl/eeprom_wp_target.sv
// Top level of the serial EEPROM target with a one-time lower-half write lock.
// Assumes an external pull-up on SDA; sda_oe_o high pulls the line low.
module eeprom_wp_target
    import eeprom_wp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic locked, wr_en, lock_set;
    logic [ADDR_W-1:0] ptr;
    logic [WORD_W-1:0] rd_data, wr_data;

    eeprom_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eeprom_bus_fsm #(.AW(ADDR_W), .DW(WORD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .strap(strap_i), .locked(locked), .rd_data(rd_data),
        .ptr_o(ptr), .wr_en(wr_en), .wr_data(wr_data), .lock_set(lock_set),
        .sda_oe(sda_oe_o)
    );

    eeprom_array #(.AW(ADDR_W), .DW(WORD_W)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(wr_data),
        .rd_addr(ptr), .rd_data(rd_data), .lock_set(lock_set), .locked(locked)
    );
endmodule

// File: tb/eeprom_wp_target_test.sv
// Bench: behavioural bus controller plus a byte-array model of the target.
module eeprom_wp_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int H = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic [2:0] strap = 3'd0;
    logic oe;
    logic sda_w;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] mem_m [256];
    logic lock_m = 1'b0;
    logic prev_oe = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_w = ~(m_low | oe);

    eeprom_wp_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_w),
        .strap_i(strap), .sda_oe_o(oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // R9: every change of the target drive must happen with SCL low.
    always @(negedge clk) begin
        if (rst_n && oe !== prev_oe) chk("R9 drive edge while SCL high", m_scl, 0);
        prev_oe <= oe;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wait_clk(H);
        m_scl = 1'b1; wait_clk(H);
        m_low = 1'b1; wait_clk(H);
        m_scl = 1'b0; wait_clk(2);
    endtask

    task automatic bus_stop();
        wait_clk(2); m_low = 1'b1; wait_clk(H);
        m_scl = 1'b1; wait_clk(H);
        m_low = 1'b0; wait_clk(H);
    endtask

    task automatic put_bit(input logic b);
        wait_clk(2); m_low = ~b; wait_clk(H);
        m_scl = 1'b1; wait_clk(H);
        m_scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        wait_clk(2); m_low = 1'b0; wait_clk(H);
        m_scl = 1'b1; wait_clk(H/2);
        b = sda_w; wait_clk(H/2);
        m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(last);
    endtask

    function automatic logic [6:0] mem_dev();
        return {4'b1010, strap};
    endfunction

    function automatic logic [6:0] lock_dev();
        return {4'b0110, strap};
    endfunction

    task automatic do_write(input logic [6:0] dev, input logic [7:0] wa, input int n,
                            input logic [7:0] seed, input string req);
        logic a;
        logic [7:0] p, d;
        bus_start();
        send_byte({dev, 1'b0}, a);
        chk({req, " ctrl ack"}, a, int'(dev == mem_dev()));
        if (a) begin
            send_byte(wa, a);
            chk({req, " word ack"}, a, 1);
            p = wa;
            for (int k = 0; k < n; k++) begin
                d = seed + 8'(k * 7);
                send_byte(d, a);
                chk({req, " data ack"}, a, 1);
                if (!(lock_m && !p[7])) mem_m[p] = d;
                p = p + 8'd1;
            end
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] wa, input int n, input string req);
        logic a;
        logic [7:0] p, d;
        bus_start();
        send_byte({mem_dev(), 1'b0}, a); chk({req, " ctrl ack"}, a, 1);
        send_byte(wa, a);                chk({req, " word ack"}, a, 1);
        bus_start();
        send_byte({mem_dev(), 1'b1}, a); chk({req, " read ack"}, a, 1);
        p = wa;
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, d);
            chk({req, " data"}, d, mem_m[p]);
            p = p + 8'd1;
        end
        wait_clk(3);
        chk({req, " released after NACK"}, oe, 0);
        bus_stop();
    endtask

    task automatic lock_quick(input int exp, input string req);
        logic a;
        bus_start();
        send_byte({lock_dev(), 1'b0}, a);
        chk({req, " quick write ack"}, a, exp);
        bus_stop();
    endtask

    task automatic lock_data(input int exp, input string req);
        logic a;
        bus_start();
        send_byte({lock_dev(), 1'b0}, a);
        chk({req, " lock ctrl ack"}, a, exp);
        if (a) begin
            send_byte(8'h00, a);
            chk({req, " lock data ack"}, a, 1);
            lock_m = 1'b1;
        end
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        wait_clk(5);
        chk("R8 SDA released in reset", oe, 0);
        rst_n = 1'b1;
        wait_clk(5);

        // R8: array reads zero after reset
        do_read(8'h40, 2, "R8 reset contents");
        // R1, R2: write and read back
        do_write(mem_dev(), 8'h10, 4, 8'h3C, "R2 burst write");
        do_read(8'h10, 4, "R3 sequential read");
        // R1: wrong address gets no acknowledge
        do_write(7'h51, 8'h10, 1, 8'hEE, "R1 foreign address");
        do_read(8'h10, 1, "R1 foreign write left data");
        // R2: pointer wrap across 0xFF
        do_write(mem_dev(), 8'hFE, 3, 8'hA1, "R2 wrap write");
        do_read(8'hFE, 3, "R3 wrap read");
        // R9: START in mid-byte abandons it
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        do_write(mem_dev(), 8'h20, 2, 8'h55, "R9 after aborted byte");
        do_read(8'h20, 2, "R9 restart read");
        // R1: strap moves the address
        strap = 3'd5;
        do_write(7'h50, 8'h30, 1, 8'h99, "R1 old address after strap change");
        do_write(mem_dev(), 8'h30, 1, 8'h77, "R1 strap address");
        do_read(8'h30, 1, "R1 strap read");
        // R4, R5: quick write and read at the lock address
        lock_quick(1, "R4 unlocked");
        begin
            logic a;
            bus_start();
            send_byte({lock_dev(), 1'b1}, a);
            chk("R5 read to lock address", a, 0);
            bus_stop();
        end
        do_write(mem_dev(), 8'h05, 1, 8'h42, "R4 low half still writable");
        do_read(8'h05, 1, "R4 low half data");
        // R6: lock, then write across the boundary
        lock_data(1, "R6 set lock");
        do_write(mem_dev(), 8'h7F, 2, 8'hC3, "R6 boundary write");
        do_read(8'h7F, 2, "R6 boundary read");
        do_write(mem_dev(), 8'h05, 1, 8'h11, "R6 protected write");
        do_read(8'h05, 1, "R6 protected data");
        // R7: lock address gone
        lock_quick(0, "R7 locked");
        lock_data(0, "R7 locked data");
        do_write(mem_dev(), 8'h06, 1, 8'h12, "R7 still locked");
        do_read(8'h06, 1, "R7 still locked data");
        // R8: only reset clears
        rst_n = 1'b0; wait_clk(4);
        chk("R8 SDA released in reset", oe, 0);
        rst_n = 1'b1; wait_clk(4);
        lock_m = 1'b0;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        do_read(8'h05, 2, "R8 cleared array");
        lock_quick(1, "R8 lock cleared");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule